// File: doc/BRIEF.md
# Priority-masked vectored interrupt acceptor

This block gathers interrupt requests from eight sources and hands the most urgent acceptable one to a processor together with a hardware-supplied vector address. Because the vector names the source, the processor never has to poll devices. Sources may be error detectors (a parity fault, for example), a front-panel button, or triggers raised by function codes. Each source owns a fixed priority level equal to its index, 0 to 7, and a vector address equal to octal 100 plus four times its index.

A request pulse is caught in a sticky pending bit. Every cycle the block finds the highest pending level and compares it with the processor's current 3-bit priority, which comes from bits 7:5 of the processor status word held outside the block. A request is accepted only when its level is strictly above that priority. An accepted request raises `irq_o` and presents its vector on `vec_o`. Both stay fixed until the processor pulses `ack_i`, and that acknowledge clears the matching pending bit.

Top module: `intr_vec_acceptor`

## Requirements
- R1: After synchronous reset, `irq_o` is 0, `vec_o` is 0 and no request is pending.
- R2: A single-cycle pulse on `req_i[i]` stays pending until that source is acknowledged. If level i is above `prio_i`, `irq_o` rises at the second rising edge after the edge that sampled the pulse, counting that sampling edge as the first.
- R3: A pending source i with i less than or equal to `prio_i` never raises `irq_o` and stays pending. It is delivered once `prio_i` drops below i. Source 0 is therefore never delivered.
- R4: When several pending sources are above `prio_i` at the moment of acceptance, the one with the highest level is delivered.
- R5: The vector for source i is 8'h40 + 4*i (octal 100 + 4*i), so level 3 gives 8'h4C, level 5 gives 8'h54, level 6 gives 8'h58 and level 7 gives 8'h5C.
- R6: While `irq_o` is high and neither an acknowledge nor a withdrawal (R8) occurs, `irq_o` stays high and `vec_o` stays unchanged, even if a higher-level request arrives.
- R7: `ack_i` sampled high while `irq_o` is high makes `irq_o` fall at that edge and clears the delivered source's pending bit. `ack_i` sampled while `irq_o` is low has no effect on any pending bit.
- R8: If, while `irq_o` is high and no acknowledge is given, `prio_i` becomes greater than or equal to the delivered level, `irq_o` falls at the next edge and the request stays pending.
- R9: A new request on a source in the same cycle as that source's acknowledge leaves the source pending, so it is delivered again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 8 | Request pulses, bit i is source i at level i |
| prio_i | input | 3 | Processor priority, status-word bits 7:5 |
| ack_i | input | 1 | Processor acknowledge of the presented vector |
| irq_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 8 | Vector address of the delivered source |

## Verification
Two functions can fall in the same cycle. The first is a source's acknowledge clearing its pending bit while the same source raises a fresh request. The bench drives both in one cycle on purpose and judges the outcome by a second delivery of the same vector. The second is a higher request, or a raised processor priority, arriving while a vector is held. For these cases the bench checks that the held vector does not move, or that the request is withdrawn and still delivered later. Random traffic mixes requests, priority changes and acknowledges so that these overlaps also happen without being planned, and each cycle is compared with a bench model built from the requirements.

// File: rtl/intr_vec_pkg.sv
package intr_vec_pkg;

  // Default vector layout: base address and spacing between sources.
  localparam int unsigned VEC_BASE_DEF = 32'o100;
  localparam int unsigned VEC_STEP_DEF = 4;

  // Vector address belonging to one priority level.
  function automatic int unsigned vec_addr(input int unsigned base,
                                           input int unsigned step,
                                           input int unsigned lvl);
    return base + step * lvl;
  endfunction

endpackage

// File: rtl/intr_pending.sv
module intr_pending #(
  parameter int N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] set_i,
  input  logic [N_SRC-1:0] clr_i,
  output logic [N_SRC-1:0] pend_o
);

  logic [N_SRC-1:0] pend_q;

  // A set in the same cycle as a clear wins, so no new request is lost.
  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= (pend_q & ~clr_i) | set_i;
  end

  assign pend_o = pend_q;

  // R2: a pending bit is dropped only by a clear.
  a_r2_sticky: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((($past(pend_q) & ~$past(clr_i)) & ~pend_q) == '0));

  // R9: every sampled request is pending afterwards, clear or not.
  a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(set_i) & ~pend_q) == '0));

endmodule

// File: rtl/intr_resolve.sv
module intr_resolve #(
  parameter  int N_SRC = 8,
  localparam int LVL_W = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] pend_i,
  input  logic [LVL_W-1:0] prio_i,
  output logic             win_valid_o,
  output logic [LVL_W-1:0] win_lvl_o
);

  logic [N_SRC-1:0] elig;
  logic [N_SRC-1:0] grant;

  // A source is eligible when pending and strictly above the processor level.
  for (genvar g = 0; g < N_SRC; g++) begin : g_elig
    assign elig[g] = pend_i[g] && (LVL_W'(g) > prio_i);
  end

  // Scan upward; the last eligible index seen is the highest level.
  always_comb begin
    win_valid_o = 1'b0;
    win_lvl_o   = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (elig[i]) begin
        win_valid_o = 1'b1;
        win_lvl_o   = LVL_W'(i);
      end
    end
    grant = win_valid_o ? (N_SRC'(1) << win_lvl_o) : '0;
  end

  // R4: nothing eligible sits above the chosen level.
  a_r4_highest: assert property (@(posedge clk) disable iff (rst)
    win_valid_o |-> ((elig >> win_lvl_o) == N_SRC'(1)));

  // R3: the chosen level is always above the processor level.
  a_r3_above_mask: assert property (@(posedge clk) disable iff (rst)
    win_valid_o |-> (win_lvl_o > prio_i));

  a_r4_grant_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

endmodule

// File: rtl/intr_handshake.sv
module intr_handshake
  import intr_vec_pkg::*;
#(
  parameter  int          N_SRC    = 8,
  parameter  int          VEC_W    = 8,
  parameter  int unsigned VEC_BASE = VEC_BASE_DEF,
  parameter  int unsigned VEC_STEP = VEC_STEP_DEF,
  localparam int          LVL_W    = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             win_valid_i,
  input  logic [LVL_W-1:0] win_lvl_i,
  input  logic [LVL_W-1:0] prio_i,
  input  logic             ack_i,
  output logic [N_SRC-1:0] clr_o,
  output logic             irq_o,
  output logic [VEC_W-1:0] vec_o
);

  logic             irq_q;
  logic [LVL_W-1:0] lvl_q;
  logic [VEC_W-1:0] vec_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
      lvl_q <= '0;
      vec_q <= '0;
    end else if (irq_q) begin
      // Acknowledge ends the handshake; a raised mask withdraws it.
      if (ack_i || (lvl_q <= prio_i)) irq_q <= 1'b0;
    end else if (win_valid_i) begin
      irq_q <= 1'b1;
      lvl_q <= win_lvl_i;
      vec_q <= VEC_W'(vec_addr(VEC_BASE, VEC_STEP, int'(win_lvl_i)));
    end
  end

  // Only an accepted acknowledge clears the delivered source.
  assign clr_o = (irq_q && ack_i) ? (N_SRC'(1) << lvl_q) : '0;
  assign irq_o = irq_q;
  assign vec_o = vec_q;

  // R6: held request keeps its vector until acknowledge or withdrawal.
  a_r6_vec_hold: assert property (@(posedge clk) disable iff (rst)
    (irq_q && !ack_i && (lvl_q > prio_i)) |=> (irq_q && $stable(vec_q)));

  // R7: an acknowledge drops the request at the next edge.
  a_r7_ack_drop: assert property (@(posedge clk) disable iff (rst)
    (irq_q && ack_i) |=> !irq_q);

  // R7: no clear without an outstanding request.
  a_r7_no_stray_clear: assert property (@(posedge clk) disable iff (rst)
    !irq_q |-> (clr_o == '0));

  // R8: a masked held level withdraws the request.
  a_r8_withdraw: assert property (@(posedge clk) disable iff (rst)
    (irq_q && (lvl_q <= prio_i)) |=> !irq_q);

  // R3: a request is only raised when the resolver had a winner.
  a_r3_raise_needs_win: assert property (@(posedge clk) disable iff (rst)
    (!irq_q && !win_valid_i) |=> !irq_q);

endmodule

// File: rtl/intr_vec_acceptor.sv
module intr_vec_acceptor
  import intr_vec_pkg::*;
#(
  parameter  int          N_SRC    = 8,
  parameter  int          VEC_W    = 8,
  parameter  int unsigned VEC_BASE = VEC_BASE_DEF,
  parameter  int unsigned VEC_STEP = VEC_STEP_DEF,
  localparam int          LVL_W    = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] req_i,
  input  logic [LVL_W-1:0] prio_i,
  input  logic             ack_i,
  output logic             irq_o,
  output logic [VEC_W-1:0] vec_o
);

  logic [N_SRC-1:0] pend;
  logic [N_SRC-1:0] clr;
  logic             win_valid;
  logic [LVL_W-1:0] win_lvl;

  intr_pending #(.N_SRC(N_SRC)) u_pending (
    .clk    (clk),
    .rst    (rst),
    .set_i  (req_i),
    .clr_i  (clr),
    .pend_o (pend)
  );

  intr_resolve #(.N_SRC(N_SRC)) u_resolve (
    .clk         (clk),
    .rst         (rst),
    .pend_i      (pend),
    .prio_i      (prio_i),
    .win_valid_o (win_valid),
    .win_lvl_o   (win_lvl)
  );

  intr_handshake #(
    .N_SRC    (N_SRC),
    .VEC_W    (VEC_W),
    .VEC_BASE (VEC_BASE),
    .VEC_STEP (VEC_STEP)
  ) u_handshake (
    .clk         (clk),
    .rst         (rst),
    .win_valid_i (win_valid),
    .win_lvl_i   (win_lvl),
    .prio_i      (prio_i),
    .ack_i       (ack_i),
    .clr_o       (clr),
    .irq_o       (irq_o),
    .vec_o       (vec_o)
  );

  // R1: quiet after reset.
  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (!irq_o && vec_o == '0));

endmodule

// File: tb/tb_intr_vec_acceptor.sv
`timescale 1ns/1ps
module tb_intr_vec_acceptor;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] req_i = '0;
  logic [2:0] prio_i = '0;
  logic       ack_i = 1'b0;
  logic       irq_o;
  logic [7:0] vec_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // Bench model state, written from the requirements.
  logic [7:0] m_pend;
  logic       m_irq;
  logic [2:0] m_lvl;
  logic [7:0] m_vec;

  always #4 clk = ~clk;

  intr_vec_acceptor dut (
    .clk(clk), .rst(rst), .req_i(req_i), .prio_i(prio_i),
    .ack_i(ack_i), .irq_o(irq_o), .vec_o(vec_o)
  );

  function automatic logic [7:0] exp_vec(input int lvl);
    return 8'(8'h40 + 4 * lvl);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_pend = '0; m_irq = 1'b0; m_lvl = '0; m_vec = '0;
  endtask

  // One clock edge of the requirement model.
  task automatic model_edge(input logic [7:0] r, input logic [2:0] p, input logic a);
    logic [7:0] clr;
    int win;
    win = -1;
    for (int i = 0; i < 8; i++) if (m_pend[i] && i > int'(p)) win = i;
    clr = (m_irq && a) ? (8'd1 << m_lvl) : 8'd0;
    if (m_irq) begin
      if (a || m_lvl <= p) m_irq = 1'b0;
    end else if (win >= 0) begin
      m_irq = 1'b1;
      m_lvl = 3'(win);
      m_vec = exp_vec(win);
    end
    m_pend = (m_pend & ~clr) | r;
  endtask

  // Drive at a falling edge, advance one rising edge, compare at the next falling edge.
  task automatic step(input logic [7:0] r, input logic [2:0] p, input logic a, input string tag);
    req_i = r; prio_i = p; ack_i = a;
    @(posedge clk);
    model_edge(r, p, a);
    @(negedge clk);
    req_i = '0; ack_i = 1'b0;
    chk({tag, " irq"}, int'(irq_o), int'(m_irq));
    chk({tag, " vec"}, int'(vec_o), int'(m_vec));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 irq after reset", int'(irq_o), 0);
    chk("R1 vec after reset", int'(vec_o), 0);
    step(8'h00, 3'd0, 1'b0, "R1 idle");

    // R2 / R5: single pulse on source 5, processor level 2.
    step(8'h20, 3'd2, 1'b0, "R2 pulse");
    chk("R2 irq not yet", int'(irq_o), 0);
    step(8'h00, 3'd2, 1'b0, "R2 wait");
    chk("R2 irq raised", int'(irq_o), 1);
    chk("R5 vector level 5", int'(vec_o), 8'h54);

    // R6: higher request while held does not move the vector.
    step(8'h80, 3'd2, 1'b0, "R6 higher arrives");
    step(8'h00, 3'd2, 1'b0, "R6 hold");
    chk("R6 vec held", int'(vec_o), 8'h54);
    chk("R6 irq held", int'(irq_o), 1);

    // R7: acknowledge, then level 7 is delivered.
    step(8'h00, 3'd2, 1'b1, "R7 ack");
    chk("R7 irq drop", int'(irq_o), 0);
    step(8'h00, 3'd2, 1'b0, "R7 next");
    chk("R5 vector level 7", int'(vec_o), 8'h5C);
    step(8'h00, 3'd2, 1'b1, "R7 ack 7");
    step(8'h00, 3'd2, 1'b0, "R7 empty");
    chk("R7 nothing left", int'(irq_o), 0);

    // R4: levels 3 and 6 pending while masked, then mask lowered.
    step(8'h48, 3'd7, 1'b0, "R4 load");
    step(8'h00, 3'd7, 1'b1, "R7 ack ignored while low");
    step(8'h00, 3'd1, 1'b0, "R4 unmask");
    step(8'h00, 3'd1, 1'b0, "R4 pick");
    chk("R4 highest wins", int'(vec_o), 8'h58);
    step(8'h00, 3'd1, 1'b1, "R4 ack 6");
    step(8'h00, 3'd1, 1'b0, "R4 next");
    chk("R4 then level 3", int'(vec_o), 8'h4C);
    step(8'h00, 3'd1, 1'b1, "R4 ack 3");

    // R3: equal level is masked, lowering the mask delivers it.
    step(8'h10, 3'd4, 1'b0, "R3 equal");
    step(8'h00, 3'd4, 1'b0, "R3 wait");
    step(8'h00, 3'd4, 1'b0, "R3 wait");
    chk("R3 equal masked", int'(irq_o), 0);
    step(8'h01, 3'd0, 1'b0, "R3 source0");
    step(8'h00, 3'd3, 1'b0, "R3 lower");
    step(8'h00, 3'd3, 1'b0, "R3 lower");
    chk("R3 delivered later", int'(vec_o), 8'h50);
    step(8'h00, 3'd3, 1'b1, "R3 ack");
    step(8'h00, 3'd0, 1'b0, "R3 src0");
    step(8'h00, 3'd0, 1'b0, "R3 src0");
    chk("R3 source 0 never", int'(irq_o), 0);

    // R8: withdraw by raising the mask, then redelivery.
    step(8'h20, 3'd2, 1'b0, "R8 pulse");
    step(8'h00, 3'd2, 1'b0, "R8 raised");
    step(8'h00, 3'd6, 1'b0, "R8 mask up");
    chk("R8 withdrawn", int'(irq_o), 0);
    step(8'h00, 3'd2, 1'b0, "R8 mask down");
    step(8'h00, 3'd2, 1'b0, "R8 again");
    chk("R8 redelivered", int'(vec_o), 8'h54);

    // R9: same source requests in the acknowledge cycle.
    step(8'h20, 3'd2, 1'b1, "R9 ack+req");
    chk("R9 irq drop", int'(irq_o), 0);
    step(8'h00, 3'd2, 1'b0, "R9 again");
    chk("R9 redelivered irq", int'(irq_o), 1);
    chk("R9 redelivered vec", int'(vec_o), 8'h54);
    step(8'h00, 3'd2, 1'b1, "R9 ack");
    step(8'h00, 3'd2, 1'b0, "R9 empty");
    chk("R9 cleared after plain ack", int'(irq_o), 0);

    // Random traffic checked each cycle against the model (R2-R9).
    for (int c = 0; c < 4000; c++) begin
      logic [7:0] r;
      logic [2:0] p;
      logic a;
      r = (($urandom % 5) == 0) ? 8'(1 << ($urandom % 8)) : 8'h00;
      if (($urandom % 13) == 0) r = 8'($urandom);
      p = (($urandom % 8) == 0) ? 3'($urandom) : prio_i;
      a = m_irq ? (($urandom % 3) == 0) : (($urandom % 16) == 0);
      step(r, p, a, "R2-R9 random");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule